// File: doc/BRIEF.md
# Addressed Serial Configuration Register Slave

This block is the digital side of one sensor node on a shared three-wire serial bus made of a frame strobe, a bit clock and a data line. Up to eight nodes sit on the same wires, and each node is told apart by a 3-bit strap address. The node keeps an 8-bit adjustment register with three fields: a feedback-capacitance select, a conversion-time select and a gain code. It also keeps an output-enable flag for its analog output. All three bus inputs are raw pins. They pass through two-flop synchronizers clocked by a system clock at least eight times faster than the bus clock, and every bus edge is detected from the synchronized samples.

A mode input selects how a frame is handled. With the mode low, a frame is 16 clocks long and is either a register write or a register read. A write lands in the register only when the strobe falls. A read sends the register contents back through a driver that has its own enable. With the mode high, a frame is 8 clocks long and selects an output. The node whose address matches turns its output-enable on, and every other node turns its own off. The board controller can therefore use the analog outputs of several nodes, one node at a time.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset the register is 8'h00, `out_en` is 0, and `sdo_en` and `sdo` are 0.
- R2: A frame begins on the strobe rise and ends on the strobe fall. Bits are sampled on bit-clock rises. Bit 1 is the direction bit (1 = read, 0 = write) and bits 2 to 4 are the address, MSB first. In a 16-bit frame, bits 5 to 8 are ignored, bits 9 to 10 are the capacitance select, bits 11 to 12 are the conversion-time select and bits 13 to 16 are the gain code. The register is {capacitance, conversion time, gain}, with the capacitance select in bits 7:6.
- R3: With the mode low, the register takes the last 8 bits of a frame when the strobe falls. This happens only if the direction bit is 0, the address equals the strap, and exactly 16 bit clocks were received.
- R4: With the mode low, a write frame with any bit-clock count other than 16 leaves the register unchanged.
- R5: With the mode high, when the strobe falls on an 8-clock frame whose direction bit is 0, `out_en` becomes 1 if the address matches the strap and 0 if it does not. Frames of this kind may follow one another with no gap.
- R6: With the mode high, when the strobe falls on a frame whose bit-clock count is not 8, `out_en` becomes 0, unless the direction bit of that frame is 1.
- R7: With the mode low, in a read frame whose address matches, `sdo_en` rises on the fall of bit clock 8. Register bits 7 down to 0 are then driven on the falls of clocks 8 through 15.
- R8: A read frame whose address does not match never asserts `sdo_en`.
- R9: `sdo_en` returns to 0 when the strobe falls.
- R10: A read frame never changes the register or `out_en`. A frame in mode high never changes the register. A frame in mode low never changes `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| se_pin | input | 1 | Raw frame strobe |
| sck_pin | input | 1 | Raw bus bit clock |
| sdi_pin | input | 1 | Raw serial data in |
| sel_mode | input | 1 | 0 = register write/read frames, 1 = output-select frames |
| strap_addr | input | 3 | Node address strap |
| cap_sel | output | 2 | Feedback-capacitance select field |
| conv_sel | output | 2 | Conversion-time select field |
| gain_code | output | 4 | Gain code field |
| out_en | output | 1 | Analog output enable |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Enable of the serial data driver |

## Verification
The bench builds the block with its default parameters: a 3-bit address, an 8-bit register and a 4-bit pad. With these values every pairing of strap and frame address (64 in all) can be covered with a write and a read-back. The expected register value is computed for each pairing. The same configuration keeps the frames short enough to try bit-clock counts of 15 and 17 in register mode, and counts of 7, 9 and 16 in select mode. It also allows read frames and mismatched frames in both modes, with the drive enable checked at every point where a bit is launched.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned ADDR_W_D = 3;
  localparam int unsigned REG_W_D  = 8;
  localparam int unsigned PAD_W_D  = 4;

  // header = direction bit + address + pad; select frame length equals header
  function automatic int unsigned hdr_len(input int unsigned aw, input int unsigned pw);
    return 1 + aw + pw;
  endfunction

  function automatic int unsigned wr_len(input int unsigned aw, input int unsigned pw,
                                         input int unsigned rw);
    return hdr_len(aw, pw) + rw;
  endfunction

  // bit position of the register driven on the fall of clock k (k counted from 1)
  function automatic int unsigned rd_index(input int unsigned k, input int unsigned hdr,
                                           input int unsigned rw);
    return rw - 1 - (k - hdr);
  endfunction
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  logic [LANES-1:0] prev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se_rise,
  input  logic              se_fall,
  input  logic              sck_rise,
  input  logic              din,
  output logic              active,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rw_bit,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  tail
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      rw_bit  <= 1'b0;
      addr    <= '0;
      tail    <= '0;
    end else if (se_rise) begin
      active  <= 1'b1;
      bit_cnt <= '0;
      rw_bit  <= 1'b0;
      addr    <= '0;
      tail    <= '0;
    end else if (se_fall) begin
      active  <= 1'b0;
    end else if (active && sck_rise) begin
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == '0) rw_bit <= din;
      if (bit_cnt >= CNT_W'(1) && bit_cnt <= CNT_W'(ADDR_W))
        addr <= {addr[ADDR_W-2:0], din};
      tail <= {tail[REG_W-2:0], din};
    end
  end
endmodule

// File: rtl/cfg_rd_drv.sv
module cfg_rd_drv #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned HDR   = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_edge,
  input  logic             sck_fall,
  input  logic             rd_frame,
  input  logic             addr_hit,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [REG_W-1:0] reg_q,
  output logic             sdo,
  output logic             sdo_en
);
  import cfg_pkg::*;
  localparam int unsigned LAST = HDR + REG_W - 1;

  logic launch_first, launch_next;
  logic [REG_W-1:0] idx_sel;

  assign launch_first = rd_frame && sck_fall && (bit_cnt == CNT_W'(HDR)) && addr_hit;
  assign launch_next  = rd_frame && sck_fall && sdo_en &&
                        (bit_cnt > CNT_W'(HDR)) && (bit_cnt <= CNT_W'(LAST));

  always_comb begin
    idx_sel = '0;
    for (int k = HDR; k <= LAST; k++)
      if (bit_cnt == CNT_W'(k)) idx_sel[rd_index(k, HDR, REG_W)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (se_edge) begin
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (launch_first || launch_next) begin
      sdo    <= |(reg_q & idx_sel);
      sdo_en <= 1'b1;
    end else if (sdo_en && sck_fall && bit_cnt > CNT_W'(LAST)) begin
      sdo    <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int unsigned ADDR_W = cfg_pkg::ADDR_W_D,
  parameter int unsigned REG_W  = cfg_pkg::REG_W_D,
  parameter int unsigned PAD_W  = cfg_pkg::PAD_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  input  logic              sel_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  output logic [1:0]        cap_sel,
  output logic [1:0]        conv_sel,
  output logic [3:0]        gain_code,
  output logic              out_en,
  output logic              sdo,
  output logic              sdo_en
);
  import cfg_pkg::*;
  localparam int unsigned HDR    = hdr_len(ADDR_W, PAD_W);
  localparam int unsigned WR_LEN = wr_len(ADDR_W, PAD_W, REG_W);
  localparam int unsigned CNT_W  = $clog2(WR_LEN + 2) + 1;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic se_rise, se_fall, sck_rise, sck_fall, din;

  cfg_bus_sync #(.LANES(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({sdi_pin, sck_pin, se_pin}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );
  assign se_rise  = s_rise[0];
  assign se_fall  = s_fall[0];
  assign sck_rise = s_rise[1];
  assign sck_fall = s_fall[1];
  assign din      = s_lvl[2];

  logic              frame_active;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rw_bit;
  logic [ADDR_W-1:0] fr_addr;
  logic [REG_W-1:0]  fr_tail;

  cfg_frame_rx #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .se_rise(se_rise), .se_fall(se_fall), .sck_rise(sck_rise), .din(din),
    .active(frame_active), .bit_cnt(bit_cnt), .rw_bit(rw_bit),
    .addr(fr_addr), .tail(fr_tail)
  );

  // named events for the checker
  logic addr_hit, rw_known, is_read, frame_end, wr_commit, sel_update, sel_value;
  assign addr_hit   = (fr_addr == strap_addr);
  assign rw_known   = (bit_cnt != '0);
  assign is_read    = rw_known && rw_bit;
  assign frame_end  = se_fall && frame_active;
  assign wr_commit  = frame_end && !sel_mode && !is_read && rw_known &&
                      (bit_cnt == CNT_W'(WR_LEN)) && addr_hit;
  assign sel_update = frame_end && sel_mode && !is_read;
  assign sel_value  = (bit_cnt == CNT_W'(HDR)) && addr_hit;

  logic [REG_W-1:0] reg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      out_en <= 1'b0;
    end else begin
      if (wr_commit)  reg_q  <= fr_tail;
      if (sel_update) out_en <= sel_value;
    end
  end

  cfg_rd_drv #(.REG_W(REG_W), .HDR(HDR), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .se_edge(se_fall || se_rise),
    .sck_fall(sck_fall),
    .rd_frame(frame_active && !sel_mode && is_read),
    .addr_hit(addr_hit),
    .bit_cnt(bit_cnt),
    .reg_q(reg_q),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  assign cap_sel   = reg_q[REG_W-1 -: 2];
  assign conv_sel  = reg_q[REG_W-3 -: 2];
  assign gain_code = reg_q[3:0];
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned HDR   = 8,
  parameter int unsigned WRL   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_mode,
  input logic [REG_W-1:0] reg_q,
  input logic             out_en,
  input logic             sdo_en,
  input logic             se_fall,
  input logic             frame_active,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rw_bit
);
  // R3 / R4: register moves only at a frame end with exactly the write length
  a_r4_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q != $past(reg_q)) |-> ($past(se_fall) && $past(bit_cnt) == CNT_W'(WRL)));

  // R10: a read frame or select mode never moves the register
  a_r10_reg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q != $past(reg_q)) |-> (!$past(rw_bit) && !$past(sel_mode)));

  // R5 / R10: output enable only moves at a frame end in select mode
  a_r5_sel_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en != $past(out_en)) |-> ($past(se_fall) && $past(sel_mode)));

  // R7: drive starts right after the fall of the last header clock
  a_r7_drive_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> ($past(bit_cnt) == CNT_W'(HDR) && $past(rw_bit)));

  // R9: strobe fall releases the driver
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    se_fall |=> !sdo_en);

  // R9: driver only enabled inside a frame
  a_r9_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> frame_active);
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .REG_W(REG_W), .CNT_W(CNT_W), .HDR(HDR), .WRL(WR_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .reg_q(reg_q), .out_en(out_en),
  .sdo_en(sdo_en), .se_fall(se_fall), .frame_active(frame_active),
  .bit_cnt(bit_cnt), .rw_bit(rw_bit)
);

// File: tb/cfg_serial_slave_bench.sv
module cfg_serial_slave_bench;
  localparam int H = 8;  // system clocks per bus half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se_pin = 1'b0, sck_pin = 1'b0, sdi_pin = 1'b0, sel_mode = 1'b0;
  logic [2:0] strap_addr = 3'd0;
  logic [1:0] cap_sel, conv_sel;
  logic [3:0] gain_code;
  logic out_en, sdo, sdo_en;

  always #5 clk = ~clk;

  cfg_serial_slave u_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .se_pin(se_pin), .sck_pin(sck_pin), .sdi_pin(sdi_pin),
    .sel_mode(sel_mode), .strap_addr(strap_addr), .cap_sel(cap_sel),
    .conv_sel(conv_sel), .gain_code(gain_code), .out_en(out_en),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] rd_bits;
  logic       rd_en_any, rd_en_all;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the n low bits of word, MSB first; captures read bits before clocks 9..16
  task automatic frame(input logic [31:0] word, input int n);
    rd_bits = '0; rd_en_any = 1'b0; rd_en_all = 1'b1;
    se_pin = 1'b1;
    wait_sys(H);
    for (int i = 0; i < n; i++) begin
      sdi_pin = word[n-1-i];
      wait_sys(H);
      if (i >= 8 && i <= 15) begin
        rd_bits[15-i] = sdo;
        rd_en_any |= sdo_en;
        rd_en_all &= sdo_en;
      end else if (i < 8) begin
        rd_en_any |= sdo_en;
      end
      sck_pin = 1'b1;
      wait_sys(H);
      sck_pin = 1'b0;
    end
    wait_sys(H);
    se_pin = 1'b0;
    wait_sys(H);
  endtask

  function automatic logic [31:0] wr_word(input logic [2:0] a, input logic [7:0] d);
    return {16'd0, 1'b0, a, 4'b0000, d};
  endfunction
  function automatic logic [31:0] rd_word(input logic [2:0] a);
    return {16'd0, 1'b1, a, 12'h000};
  endfunction
  function automatic logic [31:0] sel_word(input logic rw, input logic [2:0] a);
    return {24'd0, rw, a, 4'b0000};
  endfunction
  function automatic logic [7:0] pat(input int s, input int a);
    return 8'((s * 8 + a) * 37 + 5);
  endfunction

  logic [7:0] model;

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_sys(4);
    rst_n = 1'b1;
    wait_sys(4);
    // R1
    check("R1 reg", {cap_sel, conv_sel, gain_code}, 8'h00);
    check("R1 out_en", out_en, 0);
    check("R1 sdo_en", sdo_en, 0);
    check("R1 sdo", sdo, 0);

    // R2 R3 R7 R8: every strap against every frame address
    model = 8'h00;
    for (int s = 0; s < 8; s++) begin
      strap_addr = 3'(s);
      for (int a = 0; a < 8; a++) begin
        frame(wr_word(3'(a), pat(s, a)), 16);
        if (a == s) model = pat(s, a);
        check("R3 write", {cap_sel, conv_sel, gain_code}, model);
        check("R2 field cap", cap_sel, model[7:6]);
        frame(rd_word(3'(a)), 16);
        if (a == s) begin
          check("R7 read data", rd_bits, model);
          check("R7 read drive", rd_en_all, 1);
        end else begin
          check("R8 no drive", rd_en_any, 0);
        end
        check("R9 released", sdo_en, 0);
        check("R10 out_en kept", out_en, 0);
      end
    end

    // R4: wrong lengths with a matching address
    strap_addr = 3'd5;
    frame(wr_word(3'd5, 8'h3C), 16);
    check("R3 base", {cap_sel, conv_sel, gain_code}, 8'h3C);
    frame(wr_word(3'd5, 8'hC3) >> 1, 15);
    check("R4 15 clocks", {cap_sel, conv_sel, gain_code}, 8'h3C);
    frame({wr_word(3'd5, 8'hA5), 1'b1}, 17);
    check("R4 17 clocks", {cap_sel, conv_sel, gain_code}, 8'h3C);
    frame({wr_word(3'd5, 8'h5A), 1'b0}, 17);
    check("R4 17 clocks b", {cap_sel, conv_sel, gain_code}, 8'h3C);

    // R5 R6 R10: select mode
    sel_mode = 1'b1;
    wait_sys(2);
    for (int a = 0; a < 8; a++) begin
      frame(sel_word(1'b0, 3'(a)), 8);
      check("R5 select", out_en, (a == 5) ? 1 : 0);
    end
    frame(sel_word(1'b0, 3'd5), 8);
    frame(sel_word(1'b0, 3'd5), 8);
    check("R5 back to back", out_en, 1);
    frame(sel_word(1'b1, 3'd2), 8);
    check("R10 read in sel", out_en, 1);
    frame(sel_word(1'b1, 3'd5), 8);
    check("R10 read in sel match", out_en, 1);
    check("R10 no drive in sel", rd_en_any, 0);
    frame(sel_word(1'b0, 3'd5) >> 1, 7);
    check("R6 7 clocks", out_en, 0);
    frame(sel_word(1'b0, 3'd5), 8);
    frame({sel_word(1'b0, 3'd5), 1'b0}, 9);
    check("R6 9 clocks", out_en, 0);
    frame(sel_word(1'b0, 3'd5), 8);
    frame(wr_word(3'd5, 8'hFF), 16);
    check("R6 16 clocks", out_en, 0);
    check("R10 reg kept in sel", {cap_sel, conv_sel, gain_code}, 8'h3C);
    frame(sel_word(1'b0, 3'd5), 8);
    check("R5 reselect", out_en, 1);

    // R10: register-mode frames leave out_en alone
    sel_mode = 1'b0;
    wait_sys(2);
    frame(wr_word(3'd5, 8'h81), 16);
    check("R10 out_en after write", out_en, 1);
    check("R3 write again", {cap_sel, conv_sel, gain_code}, 8'h81);
    frame(rd_word(3'd5), 16);
    check("R7 read again", rd_bits, 8'h81);
    check("R10 reg after read", {cap_sel, conv_sel, gain_code}, 8'h81);
    check("R9 final release", sdo_en, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule